// File: doc/BRIEF.md
# Decimal Matrix Code Memory Word Codec

This block guards 32-bit memory words against multiple-cell upsets. On the write side, a data word is viewed as eight 4-bit symbols in two rows of four. For each row, the codec adds pairs of symbols as unsigned integers to form 5-bit horizontal check groups. It also XORs the two rows bit by bit to form 16 vertical check bits. The result is a 68-bit codeword. The memory array sits outside the block: it stores the codeword and later hands it back on the read side.

On a read, the same encoder logic recomputes both kinds of check bits from the received data field. Each horizontal syndrome is the 5-bit modular difference between the recomputed sum and the stored sum. Each vertical syndrome bit is the XOR of the recomputed and the stored vertical bit. A symbol whose horizontal group has a nonzero syndrome is treated as faulty. It is repaired by XORing it with the 4-bit vertical syndrome slice of its column. The corrected word and an error flag are registered on the clock.

By default one encoder serves both paths, with the read path taking it while a read is requested. A parameter can select a separate encoder for each path instead.

Top module: `dmc_codec`

## Requirements
- R1: Symbol j (0..7) is data bits [4j+3:4j], and row r holds symbols 4r..4r+3. Horizontal group g = 2r+p (p = 0,1) equals symbol (4r+p) plus symbol (4r+p+2) as unsigned integers, 5 bits wide. It appears at wr_cw[16+5g+4 : 16+5g] while rd_en is low.
- R2: Vertical check bits wr_cw[15:0] equal wr_data[15:0] XOR wr_data[31:16] while rd_en is low.
- R3: wr_cw[67:36] equals wr_data, so the codeword is data, then horizontal groups, then vertical bits.
- R4: rd_vld is high in exactly the cycle after each clock edge that samples rd_en high. rd_data and rd_err update only on such edges.
- R5: For an unmodified codeword, rd_data equals its data field and rd_err is 0.
- R6: Any set of bit flips inside one row of the data field is fully corrected, provided no horizontal pair is both touched and left with an unchanged sum. In that case rd_data equals the original word and rd_err is 1.
- R7: A flip of any single check bit (rd_cw[35:0]) leaves rd_data equal to the data field and sets rd_err to 1.
- R8: After an active-low asynchronous reset, rd_data, rd_err and rd_vld are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-path clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 32 | Word to encode |
| wr_cw | output | 68 | Codeword for storage; valid while rd_en is low (shared encoder) |
| rd_en | input | 1 | Read request; rd_cw is decoded on this edge |
| rd_cw | input | 68 | Codeword returned from storage |
| rd_data | output | 32 | Corrected data word, registered |
| rd_err | output | 1 | Some syndrome bit was nonzero, registered |
| rd_vld | output | 1 | rd_data and rd_err were loaded on the previous edge |

## Verification
The bench aims at full-row bursts whose symbol sums move by large amounts. A design that truncated the sums to 4 bits, or subtracted without wraparound, would miss or misplace these bursts and return corrupted words. Random bursts of every length from 1 to 16, in either row, check that the repair picks the right vertical slice. A design that paired or indexed symbols wrongly would damage clean symbols in the other row or column. Flips confined to the check bits must raise the flag without touching the data, which exposes any design that applies the horizontal syndrome as a correction by itself. Bursts whose pair sums cancel are left out, because the code cannot see them by construction.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   function automatic int dmc_data_w(int sym_w, int rows, int cols);
      return sym_w * rows * cols;
   endfunction

   function automatic int dmc_hchk_w(int sym_w, int rows, int cols);
      return rows * (cols / 2) * (sym_w + 1);
   endfunction

   function automatic int dmc_vchk_w(int sym_w, int cols);
      return sym_w * cols;
   endfunction
endpackage

// File: rtl/dmc_encoder.sv
module dmc_encoder
   import dmc_pkg::*;
#(
   parameter int SYM_W = 4,
   parameter int ROWS  = 2,
   parameter int COLS  = 4
) (
   input  logic [dmc_data_w(SYM_W, ROWS, COLS)-1:0] data,
   output logic [dmc_hchk_w(SYM_W, ROWS, COLS)-1:0] hchk,
   output logic [dmc_vchk_w(SYM_W, COLS)-1:0]       vchk
);
   localparam int HALF = COLS / 2;
   localparam int HG_W = SYM_W + 1;
   localparam int V_W  = dmc_vchk_w(SYM_W, COLS);

   // integer sums of paired symbols, one group per pair per row
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar p = 0; p < HALF; p++) begin : g_pair
         localparam int SA = r * COLS + p;
         localparam int SB = r * COLS + p + HALF;
         assign hchk[(r*HALF+p)*HG_W +: HG_W] =
            {1'b0, data[SA*SYM_W +: SYM_W]} + {1'b0, data[SB*SYM_W +: SYM_W]};
      end
   end

   // column parity across all rows
   for (genvar i = 0; i < V_W; i++) begin : g_vbit
      always_comb begin
         vchk[i] = 1'b0;
         for (int r = 0; r < ROWS; r++) vchk[i] = vchk[i] ^ data[r*V_W + i];
      end
   end
endmodule

// File: rtl/dmc_syndrome.sv
module dmc_syndrome
   import dmc_pkg::*;
#(
   parameter int SYM_W = 4,
   parameter int ROWS  = 2,
   parameter int COLS  = 4
) (
   input  logic [dmc_hchk_w(SYM_W, ROWS, COLS)-1:0] hcalc,
   input  logic [dmc_hchk_w(SYM_W, ROWS, COLS)-1:0] hstor,
   input  logic [dmc_vchk_w(SYM_W, COLS)-1:0]       vcalc,
   input  logic [dmc_vchk_w(SYM_W, COLS)-1:0]       vstor,
   output logic [ROWS*COLS-1:0]                     loc,
   output logic [dmc_vchk_w(SYM_W, COLS)-1:0]       vsyn,
   output logic                                     any_err
);
   localparam int HALF = COLS / 2;
   localparam int HG_W = SYM_W + 1;
   localparam int NGRP = ROWS * HALF;

   logic [NGRP-1:0] grp_bad;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic [HG_W-1:0] diff;
      assign diff       = hcalc[g*HG_W +: HG_W] - hstor[g*HG_W +: HG_W];
      assign grp_bad[g] = |diff;
   end

   assign vsyn = vcalc ^ vstor;

   for (genvar r = 0; r < ROWS; r++) begin : g_lrow
      for (genvar c = 0; c < COLS; c++) begin : g_lcol
         assign loc[r*COLS+c] = grp_bad[r*HALF + (c % HALF)];
      end
   end

   assign any_err = (|grp_bad) | (|vsyn);
endmodule

// File: rtl/dmc_corrector.sv
module dmc_corrector
   import dmc_pkg::*;
#(
   parameter int SYM_W = 4,
   parameter int ROWS  = 2,
   parameter int COLS  = 4
) (
   input  logic [dmc_data_w(SYM_W, ROWS, COLS)-1:0] din,
   input  logic [ROWS*COLS-1:0]                     loc,
   input  logic [dmc_vchk_w(SYM_W, COLS)-1:0]       vsyn,
   output logic [dmc_data_w(SYM_W, ROWS, COLS)-1:0] dout
);
   for (genvar r = 0; r < ROWS; r++) begin : g_crow
      for (genvar c = 0; c < COLS; c++) begin : g_ccol
         localparam int J = r * COLS + c;
         assign dout[J*SYM_W +: SYM_W] = din[J*SYM_W +: SYM_W] ^
            (loc[J] ? vsyn[c*SYM_W +: SYM_W] : {SYM_W{1'b0}});
      end
   end
endmodule

// File: rtl/dmc_codec.sv
module dmc_codec
   import dmc_pkg::*;
#(
   parameter int SYM_W      = 4,
   parameter int ROWS       = 2,
   parameter int COLS       = 4,
   parameter bit SHARED_ENC = 1'b1
) (
   input  logic                                                clk,
   input  logic                                                rst_n,
   input  logic [SYM_W*ROWS*COLS-1:0]                          wr_data,
   output logic [SYM_W*ROWS*COLS+ROWS*(COLS/2)*(SYM_W+1)+SYM_W*COLS-1:0] wr_cw,
   input  logic                                                rd_en,
   input  logic [SYM_W*ROWS*COLS+ROWS*(COLS/2)*(SYM_W+1)+SYM_W*COLS-1:0] rd_cw,
   output logic [SYM_W*ROWS*COLS-1:0]                          rd_data,
   output logic                                                rd_err,
   output logic                                                rd_vld
);
   localparam int DATA_W = dmc_data_w(SYM_W, ROWS, COLS);
   localparam int H_W    = dmc_hchk_w(SYM_W, ROWS, COLS);
   localparam int V_W    = dmc_vchk_w(SYM_W, COLS);
   localparam int CW_W   = DATA_W + H_W + V_W;
   localparam int NSYM   = ROWS * COLS;

   if (COLS % 2 != 0) begin : g_bad_cols
      $error("dmc_codec: COLS must be even for symbol pairing");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("dmc_codec: ROWS must be at least 2");
   end
   if (SYM_W < 1) begin : g_bad_sym
      $error("dmc_codec: SYM_W must be positive");
   end

   logic [DATA_W-1:0] rx_data;
   logic [H_W-1:0]    rx_h, rc_h, wc_h;
   logic [V_W-1:0]    rx_v, rc_v, wc_v;

   assign rx_data = rd_cw[CW_W-1 -: DATA_W];
   assign rx_h    = rd_cw[V_W +: H_W];
   assign rx_v    = rd_cw[V_W-1:0];

   if (SHARED_ENC) begin : g_shared
      logic [DATA_W-1:0] enc_in;
      logic [H_W-1:0]    enc_h;
      logic [V_W-1:0]    enc_v;
      assign enc_in = rd_en ? rx_data : wr_data;
      dmc_encoder #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_enc (
         .data(enc_in), .hchk(enc_h), .vchk(enc_v));
      assign rc_h = enc_h;
      assign rc_v = enc_v;
      assign wc_h = enc_h;
      assign wc_v = enc_v;
   end else begin : g_split
      dmc_encoder #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_enc_wr (
         .data(wr_data), .hchk(wc_h), .vchk(wc_v));
      dmc_encoder #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_enc_rd (
         .data(rx_data), .hchk(rc_h), .vchk(rc_v));
   end

   assign wr_cw = {wr_data, wc_h, wc_v};

   logic [NSYM-1:0]   loc;
   logic [V_W-1:0]    vsyn;
   logic              any_err;
   logic [DATA_W-1:0] fixed;

   dmc_syndrome #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_syn (
      .hcalc(rc_h), .hstor(rx_h), .vcalc(rc_v), .vstor(rx_v),
      .loc(loc), .vsyn(vsyn), .any_err(any_err));

   dmc_corrector #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_cor (
      .din(rx_data), .loc(loc), .vsyn(vsyn), .dout(fixed));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_err  <= 1'b0;
         rd_vld  <= 1'b0;
      end else begin
         rd_vld <= rd_en;
         if (rd_en) begin
            rd_data <= fixed;
            rd_err  <= any_err;
         end
      end
   end

   // R4: valid strobe follows the request by one edge
   assert_vld_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_vld);
   assert_vld_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_vld);
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data) && $stable(rd_err));
   // R5: clean syndromes give the stored data and no flag
   assert_clean_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !any_err |=> !rd_err && rd_data == $past(rx_data));
   // R7: a symbol nobody located is never altered
   assert_unlocated_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && loc == '0 |=> rd_data == $past(rx_data));
   // R6: any nonzero syndrome raises the flag
   assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && any_err |=> rd_err);
endmodule

// File: tb/tb_dmc_codec.sv
`timescale 1ns/1ps
module tb_dmc_codec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] wr_data = '0;
   logic [67:0] wr_cw;
   logic        rd_en = 1'b0;
   logic [67:0] rd_cw = '0;
   logic [31:0] rd_data;
   logic        rd_err;
   logic        rd_vld;

   int checks = 0;
   int errors = 0;
   int seed_sink;

   always #10 clk = ~clk;

   dmc_codec dut (.clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_cw(wr_cw),
                  .rd_en(rd_en), .rd_cw(rd_cw), .rd_data(rd_data),
                  .rd_err(rd_err), .rd_vld(rd_vld));

   function automatic logic [3:0] sym(input logic [31:0] d, input int j);
      return d[j*4 +: 4];
   endfunction

   function automatic logic [67:0] ref_cw(input logic [31:0] d);
      logic [19:0] h;
      logic [15:0] v;
      for (int r = 0; r < 2; r++)
         for (int p = 0; p < 2; p++)
            h[(r*2+p)*5 +: 5] = 5'(sym(d, 4*r+p)) + 5'(sym(d, 4*r+p+2));
      v = d[15:0] ^ d[31:16];
      return {d, h, v};
   endfunction

   // true when some touched pair keeps its sum, which the code cannot see
   function automatic bit cancels(input logic [31:0] d, input logic [31:0] m);
      logic [31:0] e = d ^ m;
      for (int r = 0; r < 2; r++)
         for (int p = 0; p < 2; p++) begin
            int a = 4*r+p, b = 4*r+p+2;
            int s0 = int'(sym(d, a)) + int'(sym(d, b));
            int s1 = int'(sym(e, a)) + int'(sym(e, b));
            if ((sym(m, a) != 0 || sym(m, b) != 0) && s0 == s1) return 1'b1;
         end
      return 1'b0;
   endfunction

   task automatic chk(input string req, input logic [67:0] act, input logic [67:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [67:0] cw);
      @(negedge clk);
      rd_cw = cw;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic enc_check(input logic [31:0] d);
      logic [67:0] e;
      @(negedge clk);
      wr_data = d;
      #1;
      e = ref_cw(d);
      chk("R3", 68'(wr_cw[67:36]), 68'(e[67:36]));
      chk("R1", 68'(wr_cw[35:16]), 68'(e[35:16]));
      chk("R2", 68'(wr_cw[15:0]),  68'(e[15:0]));
   endtask

   task automatic burst_check(input logic [31:0] d, input logic [31:0] m);
      do_read(ref_cw(d) ^ {m, 36'h0});
      chk("R6 data", 68'(rd_data), 68'(d));
      chk("R6 flag", 68'(rd_err), 68'(m != 0));
   endtask

   function automatic logic [31:0] burst_mask(input int row, input int len, input int start);
      logic [31:0] m = (32'hFFFF >> (16 - len));
      return m << (start + 16*row);
   endfunction

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      seed_sink = $urandom(32'h00C0DE51);
      #35;
      // R8 reset state
      chk("R8 data", 68'(rd_data), 68'h0);
      chk("R8 err",  68'(rd_err),  68'h0);
      chk("R8 vld",  68'(rd_vld),  68'h0);
      rst_n = 1'b1;

      // R1 R2 R3 encoding, directed and random
      enc_check(32'h0000_0000);
      enc_check(32'hFFFF_FFFF);
      enc_check(32'h1234_ABCD);
      for (int i = 0; i < 40; i++) enc_check($urandom);

      // R5 clean reads and R4 timing
      for (int i = 0; i < 40; i++) begin
         logic [31:0] d = $urandom;
         do_read(ref_cw(d));
         chk("R4 vld", 68'(rd_vld), 68'h1);
         chk("R5 data", 68'(rd_data), 68'(d));
         chk("R5 err", 68'(rd_err), 68'h0);
         @(negedge clk);
         chk("R4 idle", 68'(rd_vld), 68'h0);
         chk("R4 hold", 68'(rd_data), 68'(d));
      end

      // R6 directed full-row bursts with maximal sum shifts
      burst_check(32'h0000_0000, 32'h0000_FFFF);
      burst_check(32'h0000_0000, 32'hFFFF_0000);
      burst_check(32'hFFFF_FFFF, 32'h0000_FFFF);
      burst_check(32'h5A5A_0F0F, 32'h0000_0001);
      burst_check(32'h8765_4321, 32'h8000_0000);

      // R6 random bursts in one row
      for (int i = 0; i < 400; i++) begin
         logic [31:0] d = $urandom;
         int row = int'($urandom % 2);
         int len = 1 + int'($urandom % 16);
         int st  = int'($urandom % (17 - len));
         logic [31:0] m = burst_mask(row, len, st);
         if (!cancels(d, m)) burst_check(d, m);
      end

      // R7 single check-bit flips
      for (int i = 0; i < 36; i++) begin
         logic [31:0] d = $urandom;
         logic [67:0] f = 68'h1 << i;
         do_read(ref_cw(d) ^ f);
         chk("R7 data", 68'(rd_data), 68'(d));
         chk("R7 err", 68'(rd_err), 68'h1);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule